// File: doc/BRIEF.md
# Activity and Inactivity Motion Monitor

This block watches a stream of three-axis acceleration samples and raises two sticky event flags. The activity flag goes up when any participating axis moves further than a programmed level. The inactivity flag goes up when every participating axis has stayed within its level for a programmed number of one-second ticks. Each function has its own threshold, its own axis participation mask, and its own coupling choice. With DC coupling, the raw sample magnitude is compared. With AC coupling, the compare uses the distance from a captured reference sample.

A link option turns the two functions into an alternating pair, governed by a three-state machine:

- `ST_FREE`: both functions run independently. It moves to `ST_SEEK_QUIET` when link is requested and both functions have at least one axis enabled.
- `ST_SEEK_QUIET`: only inactivity runs. An inactivity detection moves it to `ST_SEEK_MOTION`.
- `ST_SEEK_MOTION`: only activity runs. An activity detection moves it back to `ST_SEEK_QUIET`.
- Either linked state returns to `ST_FREE` as soon as the link condition drops.

When auto-sleep is also set, an inactivity detection in `ST_SEEK_QUIET` raises an asleep status, and the next activity detection lowers it. A host clears both event flags with a single-cycle strobe. For each activity event, a one-hot field reports which axis caused it.

Top module: `motion_monitor`

## Requirements
- R1: After reset, `act_evt`, `quiet_evt`, `act_src` and `asleep` are all 0.
- R2: With DC activity coupling, a valid sample sets `act_evt` at the next clock edge when any enabled axis has a magnitude strictly greater than `act_thr`. A magnitude equal to the threshold does not set it.
- R3: With AC activity coupling, the first valid sample after activity starts running becomes the reference and never triggers. Later samples trigger when the magnitude of (sample minus reference) on an enabled axis exceeds `act_thr`. The first valid sample after each detection becomes the new reference.
- R4: On each activity detection, `act_src` is overwritten with a one-hot code: bit 0 for X, bit 1 for Y, bit 2 for Z. The set bit is the lowest-indexed enabled axis that exceeded the threshold on that sample.
- R5: An axis whose enable bit is 0 neither triggers nor blocks its function. An all-zero mask disables that function entirely.
- R6: With DC inactivity coupling, a valid sample on which every enabled axis has magnitude at most `quiet_thr` starts a quiet period. Each `sec_tick` during the quiet period advances a timer, and `quiet_evt` sets on the edge after the timer reaches `quiet_time`. With `quiet_time` = 0, it sets on the second edge after the quiet sample. Any loud sample zeroes the timer and ends the quiet period. A detection also ends the quiet period.
- R7: With AC inactivity coupling, the first sample after inactivity starts running is the reference. Every loud sample, meaning one whose distance from the reference exceeds `quiet_thr`, replaces the reference with itself.
- R8: Both event flags stay set until `evt_clr`. A new event in the same cycle as `evt_clr` wins.
- R9: With `link_en` set and both masks non-zero, activity cannot fire until inactivity has been detected. After that, only activity runs until it fires, then only inactivity runs, alternating.
- R10: With `link_en` and `autosleep_en` set, an inactivity detection raises `asleep`. An activity detection lowers it. Dropping either bit lowers it on the next edge.
- R11: An inactivity detection does not raise `asleep` while `act_evt` is still set, although the link state still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe, one cycle per sample |
| smp_x | input | SW | X sample, two's complement |
| smp_y | input | SW | Y sample, two's complement |
| smp_z | input | SW | Z sample, two's complement |
| sec_tick | input | 1 | One-cycle pulse each second |
| act_thr | input | TW | Activity level, unsigned |
| quiet_thr | input | TW | Inactivity level, unsigned |
| quiet_time | input | TIME_W | Inactivity period in ticks |
| act_ac | input | 1 | Activity coupling, 1 = AC |
| quiet_ac | input | 1 | Inactivity coupling, 1 = AC |
| act_axis_en | input | 3 | Activity axis mask, bit 0 = X |
| quiet_axis_en | input | 3 | Inactivity axis mask, bit 0 = X |
| link_en | input | 1 | Chain the two functions |
| autosleep_en | input | 1 | Allow linked inactivity to enter sleep |
| evt_clr | input | 1 | Clear both event flags |
| act_evt | output | 1 | Sticky activity event |
| quiet_evt | output | 1 | Sticky inactivity event |
| act_src | output | 3 | One-hot axis of the last activity event |
| asleep | output | 1 | Sleep status |

## Verification
The threshold-equality case is the first target. A design that compares with greater-or-equal fires on a sample sitting exactly at the level.

AC coupling is exercised with references far from zero. A design that ignores the reference never sees quiet at a large static offset. A design that fails to reload it after a loud sample stays loud forever.

The inactivity timer is probed one tick short and after a loud restart. This catches an off-by-one terminal count and a timer that keeps counting across motion.

Linked sequences check three things: that activity is held off before the first quiet period, that inactivity is silent while motion is sought, and that sleep is refused while an uncleared activity event remains.

// File: rtl/mm_pkg.sv
`timescale 1ns/1ps
package mm_pkg;

    localparam int unsigned NUM_AXES = 3;

    typedef enum logic [1:0] {
        ST_FREE        = 2'd0,
        ST_SEEK_QUIET  = 2'd1,
        ST_SEEK_MOTION = 2'd2
    } link_state_t;

    // Lowest-index set bit as a one-hot code (X has priority).
    function automatic logic [NUM_AXES-1:0] first_axis(input logic [NUM_AXES-1:0] hits);
        logic [NUM_AXES-1:0] res;
        res = '0;
        for (int i = NUM_AXES - 1; i >= 0; i--) begin
            if (hits[i]) res = NUM_AXES'(1) << i;
        end
        return res;
    endfunction

endpackage

// File: rtl/mm_axis_gauge.sv
`timescale 1ns/1ps
// One axis: reference register plus coupled magnitude compare.
module mm_axis_gauge #(
    parameter int SW = 12,
    parameter int TW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 ac,
    input  logic                 ref_ok,
    input  logic signed [SW-1:0] smp,
    input  logic [TW-1:0]        thr,
    output logic                 over
);
    localparam int DW = SW + 1;

    logic signed [SW-1:0] ref_q;
    logic signed [SW-1:0] base;
    logic signed [DW-1:0] diff;
    logic [DW-1:0]        mag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ref_q <= '0;
        else if (load) ref_q <= smp;
    end

    always_comb begin
        if (!ac)         base = '0;
        else if (ref_ok) base = ref_q;
        else             base = smp;   // first sample is its own reference
        diff = $signed({smp[SW-1], smp}) - $signed({base[SW-1], base});
        mag  = diff[DW-1] ? $unsigned(-diff) : $unsigned(diff);
        over = mag > {{(DW-TW){1'b0}}, thr};
    end
endmodule

// File: rtl/mm_motion_front.sv
`timescale 1ns/1ps
// Three coupled axis gauges sharing a reference-valid flag.
module mm_motion_front
    import mm_pkg::*;
#(
    parameter int SW = 12,
    parameter int TW = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           run,
    input  logic                           ac,
    input  logic [NUM_AXES-1:0]            en,
    input  logic                           vld,
    input  logic [NUM_AXES-1:0][SW-1:0]    smp,
    input  logic [TW-1:0]                  thr,
    input  logic                           reload,
    input  logic                           drop,
    output logic [NUM_AXES-1:0]            over
);
    logic                ref_ok_q;
    logic                load;
    logic [NUM_AXES-1:0] raw_over;

    assign load = run && vld && (!ref_ok_q || reload);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ref_ok_q <= 1'b0;
        else if (!run) ref_ok_q <= 1'b0;
        else if (drop) ref_ok_q <= 1'b0;
        else if (vld)  ref_ok_q <= 1'b1;
    end

    for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
        mm_axis_gauge #(.SW(SW), .TW(TW)) u_gauge (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (load),
            .ac     (ac),
            .ref_ok (ref_ok_q),
            .smp    ($signed(smp[a])),
            .thr    (thr),
            .over   (raw_over[a])
        );
        assign over[a] = run && vld && en[a] && raw_over[a];
    end
endmodule

// File: rtl/mm_quiet_timer.sv
`timescale 1ns/1ps
// Quiet-period tracker counting second ticks.
module mm_quiet_timer #(
    parameter int TIME_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              vld,
    input  logic              loud,
    input  logic              tick,
    input  logic [TIME_W-1:0] limit,
    output logic              hit
);
    logic              quiet_q;
    logic [TIME_W-1:0] cnt_q;

    assign hit = run && quiet_q && (cnt_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_q <= 1'b0;
            cnt_q   <= '0;
        end else if (!run || hit || (vld && loud)) begin
            quiet_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            if (vld) quiet_q <= 1'b1;
            if (tick && quiet_q && (cnt_q != '1)) cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mm_link_fsm.sv
`timescale 1ns/1ps
// Link sequencing and auto-sleep status.
module mm_link_fsm
    import mm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic linked,
    input  logic autosleep,
    input  logic act_hit,
    input  logic quiet_hit,
    input  logic act_pending,
    output logic act_gate,
    output logic quiet_gate,
    output logic asleep
);
    link_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE:        if (linked) state_d = ST_SEEK_QUIET;
            ST_SEEK_QUIET:  if (!linked) state_d = ST_FREE;
                            else if (quiet_hit) state_d = ST_SEEK_MOTION;
            ST_SEEK_MOTION: if (!linked) state_d = ST_FREE;
                            else if (act_hit) state_d = ST_SEEK_QUIET;
            default:        state_d = ST_FREE;
        endcase
    end

    always_comb begin
        act_gate   = 1'b0;
        quiet_gate = 1'b0;
        unique case (state_q)
            ST_FREE:        begin act_gate = 1'b1; quiet_gate = 1'b1; end
            ST_SEEK_QUIET:  quiet_gate = 1'b1;
            ST_SEEK_MOTION: act_gate = 1'b1;
            default:        ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            asleep <= 1'b0;
        else if (!(linked && autosleep))
            asleep <= 1'b0;
        else if (state_q == ST_SEEK_MOTION && act_hit)
            asleep <= 1'b0;
        else if (state_q == ST_SEEK_QUIET && quiet_hit && !act_pending)
            asleep <= 1'b1;
    end
endmodule

// File: rtl/motion_monitor.sv
`timescale 1ns/1ps
module motion_monitor
    import mm_pkg::*;
#(
    parameter int SW     = 12,
    parameter int TW     = 8,
    parameter int TIME_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [SW-1:0]     smp_x,
    input  logic [SW-1:0]     smp_y,
    input  logic [SW-1:0]     smp_z,
    input  logic              sec_tick,
    input  logic [TW-1:0]     act_thr,
    input  logic [TW-1:0]     quiet_thr,
    input  logic [TIME_W-1:0] quiet_time,
    input  logic              act_ac,
    input  logic              quiet_ac,
    input  logic [2:0]        act_axis_en,
    input  logic [2:0]        quiet_axis_en,
    input  logic              link_en,
    input  logic              autosleep_en,
    input  logic              evt_clr,
    output logic              act_evt,
    output logic              quiet_evt,
    output logic [2:0]        act_src,
    output logic              asleep
);
    logic [NUM_AXES-1:0][SW-1:0] smp_bus;
    logic [NUM_AXES-1:0]         act_over, quiet_over;
    logic act_on, quiet_on, linked;
    logic act_gate, quiet_gate, act_run, quiet_run;
    logic act_hit, quiet_hit, quiet_loud;

    assign smp_bus   = {smp_z, smp_y, smp_x};
    assign act_on    = |act_axis_en;
    assign quiet_on  = |quiet_axis_en;
    assign linked    = link_en && act_on && quiet_on;
    assign act_run   = act_on && act_gate;
    assign quiet_run = quiet_on && quiet_gate;
    assign act_hit   = |act_over;
    assign quiet_loud = |quiet_over;

    mm_motion_front #(.SW(SW), .TW(TW)) u_act_front (
        .clk(clk), .rst_n(rst_n), .run(act_run), .ac(act_ac),
        .en(act_axis_en), .vld(smp_vld), .smp(smp_bus), .thr(act_thr),
        .reload(1'b0), .drop(act_hit), .over(act_over)
    );

    mm_motion_front #(.SW(SW), .TW(TW)) u_quiet_front (
        .clk(clk), .rst_n(rst_n), .run(quiet_run), .ac(quiet_ac),
        .en(quiet_axis_en), .vld(smp_vld), .smp(smp_bus), .thr(quiet_thr),
        .reload(quiet_loud), .drop(1'b0), .over(quiet_over)
    );

    mm_quiet_timer #(.TIME_W(TIME_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(quiet_run), .vld(smp_vld),
        .loud(quiet_loud), .tick(sec_tick), .limit(quiet_time), .hit(quiet_hit)
    );

    mm_link_fsm u_link (
        .clk(clk), .rst_n(rst_n), .linked(linked), .autosleep(autosleep_en),
        .act_hit(act_hit), .quiet_hit(quiet_hit), .act_pending(act_evt),
        .act_gate(act_gate), .quiet_gate(quiet_gate), .asleep(asleep)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_evt   <= 1'b0;
            quiet_evt <= 1'b0;
            act_src   <= '0;
        end else begin
            if (act_hit) begin
                act_evt <= 1'b1;
                act_src <= first_axis(act_over);
            end else if (evt_clr) begin
                act_evt <= 1'b0;
            end
            if (quiet_hit)    quiet_evt <= 1'b1;
            else if (evt_clr) quiet_evt <= 1'b0;
        end
    end
endmodule

// File: rtl/mm_checker.sv
`timescale 1ns/1ps
module mm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       smp_vld,
    input logic [2:0] act_axis_en,
    input logic [2:0] quiet_axis_en,
    input logic       link_en,
    input logic       autosleep_en,
    input logic       evt_clr,
    input logic       act_evt,
    input logic       quiet_evt,
    input logic [2:0] act_src,
    input logic       asleep
);
    a_r2_act_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_evt) |-> $past(smp_vld));
    a_r4_src_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act_src));
    a_r4_src_present: assert property (@(posedge clk) disable iff (!rst_n)
        act_evt |-> (act_src != 3'b000));
    a_r5_act_mask_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_evt) |-> $past(|act_axis_en));
    a_r5_quiet_mask_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(quiet_evt) |-> $past(|quiet_axis_en));
    a_r8_act_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        act_evt && !evt_clr |=> act_evt);
    a_r8_quiet_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_evt && !evt_clr |=> quiet_evt);
    a_r8_act_clear: assert property (@(posedge clk) disable iff (!rst_n)
        evt_clr && !smp_vld |=> !act_evt);
    a_r10_sleep_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> $past(link_en && autosleep_en));
    a_r10_sleep_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !(link_en && autosleep_en) |=> !asleep);
    a_r10_sleep_with_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> quiet_evt);
    a_r11_sleep_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> !$past(act_evt));
endmodule

bind motion_monitor mm_checker u_chk (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
    .act_axis_en(act_axis_en), .quiet_axis_en(quiet_axis_en),
    .link_en(link_en), .autosleep_en(autosleep_en), .evt_clr(evt_clr),
    .act_evt(act_evt), .quiet_evt(quiet_evt), .act_src(act_src), .asleep(asleep)
);

// File: tb/sim_motion_monitor.sv
`timescale 1ns/1ps
module sim_motion_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic [11:0] smp_x = '0, smp_y = '0, smp_z = '0;
    logic        sec_tick = 1'b0;
    logic [7:0]  act_thr = 8'd100, quiet_thr = 8'd50, quiet_time = 8'd0;
    logic        act_ac = 1'b0, quiet_ac = 1'b0;
    logic [2:0]  act_axis_en = 3'b111, quiet_axis_en = 3'b000;
    logic        link_en = 1'b0, autosleep_en = 1'b0, evt_clr = 1'b0;
    logic        act_evt, quiet_evt, asleep;
    logic [2:0]  act_src;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    motion_monitor u0 (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
        .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z), .sec_tick(sec_tick),
        .act_thr(act_thr), .quiet_thr(quiet_thr), .quiet_time(quiet_time),
        .act_ac(act_ac), .quiet_ac(quiet_ac),
        .act_axis_en(act_axis_en), .quiet_axis_en(quiet_axis_en),
        .link_en(link_en), .autosleep_en(autosleep_en), .evt_clr(evt_clr),
        .act_evt(act_evt), .quiet_evt(quiet_evt), .act_src(act_src), .asleep(asleep)
    );

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Expected one-hot source for one sample against references (0 = no event).
    function automatic int exp_src(input int x, input int y, input int z,
                                   input int r0, input int r1, input int r2,
                                   input logic [2:0] en, input int thr);
        if (en[0] && iabs(x - r0) > thr) return 1;
        if (en[1] && iabs(y - r1) > thr) return 2;
        if (en[2] && iabs(z - r2) > thr) return 4;
        return 0;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input int x, input int y, input int z);
        smp_x = 12'(x); smp_y = 12'(y); smp_z = 12'(z);
        smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic tick();
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic clear();
        evt_clr = 1'b1;
        @(negedge clk);
        evt_clr = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed_v;
        int e, thr, r0, r1, r2, x, y, z;
        logic ok;
        logic [2:0] en;
        seed_v = $urandom(32'd2718);

        step(2);
        // R1 reset values
        check("R1 act_evt", act_evt, 0);
        check("R1 quiet_evt", quiet_evt, 0);
        check("R1 act_src", act_src, 0);
        check("R1 asleep", asleep, 0);
        rst_n = 1'b1;
        step(3);

        // R2 equality boundary, DC activity
        act_thr = 8'd100;
        clear();
        send(100, -100, 0);
        check("R2 equal no event", act_evt, 0);
        send(-101, 0, 0);
        check("R2 above fires", act_evt, 1);
        check("R4 src X", act_src, 1);
        // R4 priority between Y and Z
        clear();
        send(20, -300, 400);
        check("R4 src Y over Z", act_src, 2);
        // R5 masked axis
        act_axis_en = 3'b110;
        clear();
        send(900, 0, 0);
        check("R5 masked X ignored", act_evt, 0);
        act_axis_en = 3'b000;
        send(0, 900, 900);
        check("R5 all masked", act_evt, 0);

        // R2 / R4 random DC
        for (int i = 0; i < 40; i++) begin
            x = int'($urandom_range(600)) - 300;
            y = int'($urandom_range(600)) - 300;
            z = int'($urandom_range(600)) - 300;
            thr = int'($urandom_range(250, 20));
            en = 3'($urandom_range(7, 1));
            act_thr = 8'(thr);
            act_axis_en = en;
            clear();
            send(x, y, z);
            e = exp_src(x, y, z, 0, 0, 0, en, thr);
            check("R2 random DC", act_evt, (e != 0) ? 1 : 0);
            if (e != 0) check("R4 random src", act_src, e);
        end

        // R3 random AC activity
        act_ac = 1'b1;
        act_axis_en = 3'b111;
        act_thr = 8'd60;
        do_reset();
        ok = 1'b0;
        r0 = 0; r1 = 0; r2 = 0;
        for (int i = 0; i < 40; i++) begin
            x = int'($urandom_range(400)) - 200;
            y = int'($urandom_range(400)) - 200;
            z = int'($urandom_range(400)) - 200;
            clear();
            send(x, y, z);
            if (!ok) begin
                e = 0; r0 = x; r1 = y; r2 = z; ok = 1'b1;
            end else begin
                e = exp_src(x, y, z, r0, r1, r2, 3'b111, 60);
                if (e != 0) ok = 1'b0;
            end
            check("R3 random AC", act_evt, (e != 0) ? 1 : 0);
            if (e != 0) check("R4 AC src", act_src, e);
        end
        act_ac = 1'b0;

        // R6 DC inactivity timer
        act_axis_en = 3'b000;
        quiet_axis_en = 3'b111;
        quiet_thr = 8'd50;
        quiet_time = 8'd3;
        clear();
        send(10, -20, 50);
        tick(); tick();
        step(2);
        check("R6 one tick short", quiet_evt, 0);
        send(0, 0, 51);
        tick(); tick(); tick();
        step(1);
        check("R6 loud restarts", quiet_evt, 0);
        send(5, 5, 5);
        tick(); tick(); tick();
        step(1);
        check("R6 full period", quiet_evt, 1);
        quiet_time = 8'd0;
        clear();
        send(1, 1, 1);
        check("R6 zero time not yet", quiet_evt, 0);
        step(1);
        check("R6 zero time fires", quiet_evt, 1);
        // R5 masked axis for inactivity
        quiet_axis_en = 3'b011;
        clear();
        send(5, 5, 900);
        step(1);
        check("R5 masked Z quiet", quiet_evt, 1);

        // R7 AC inactivity
        quiet_axis_en = 3'b000;
        step(1);
        quiet_axis_en = 3'b111;
        quiet_ac = 1'b1;
        quiet_time = 8'd2;
        clear();
        send(500, -300, 250);
        tick(); tick();
        step(1);
        check("R7 offset reference quiet", quiet_evt, 1);
        clear();
        send(600, -300, 250);
        tick(); tick();
        step(1);
        check("R7 loud reloads", quiet_evt, 0);
        send(620, -290, 260);
        tick(); tick();
        step(1);
        check("R7 near new reference", quiet_evt, 1);
        // R8 sticky and clear
        step(5);
        check("R8 sticky", quiet_evt, 1);
        clear();
        check("R8 cleared", quiet_evt, 0);
        quiet_ac = 1'b0;

        // R9 link sequencing
        act_axis_en = 3'b111;
        quiet_axis_en = 3'b111;
        act_thr = 8'd100;
        quiet_thr = 8'd50;
        quiet_time = 8'd1;
        link_en = 1'b1;
        autosleep_en = 1'b0;
        do_reset();
        send(300, 0, 0);
        check("R9 activity held off", act_evt, 0);
        send(10, 10, 10);
        tick();
        step(1);
        check("R9 inactivity first", quiet_evt, 1);
        clear();
        send(10, 10, 10);
        tick();
        step(2);
        check("R9 inactivity idle while seeking motion", quiet_evt, 0);
        send(0, 300, 0);
        check("R9 activity after quiet", act_evt, 1);
        check("R4 linked src", act_src, 2);
        clear();
        send(300, 0, 0);
        check("R9 held off again", act_evt, 0);

        // R10 / R11 auto-sleep
        autosleep_en = 1'b1;
        do_reset();
        send(10, 10, 10);
        tick();
        step(1);
        check("R10 quiet event", quiet_evt, 1);
        check("R10 asleep set", asleep, 1);
        send(0, 0, -300);
        check("R10 wake event", act_evt, 1);
        check("R4 wake src Z", act_src, 4);
        check("R10 asleep cleared", asleep, 0);
        send(10, 10, 10);
        tick();
        step(1);
        check("R11 sleep refused", asleep, 0);
        clear();
        send(300, 0, 0);
        check("R11 link still advanced", act_evt, 1);
        clear();
        send(10, 10, 10);
        tick();
        step(1);
        check("R10 asleep again", asleep, 1);
        autosleep_en = 1'b0;
        step(1);
        check("R10 drop autosleep", asleep, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule